// File: doc/BRIEF.md
# Pulse-Width Frame Bus Master Engine

This block is the master side of a three-wire serial bus. A frame line marks each message, a transmit data line carries one pulse per bit, and a return data line carries the slave's reply. The slave answers in the same bit slots as the master. When a data word is offered on the transmit stream and the engine is idle, it pulls the frame line low. It then waits one bit time and sends the data bits followed by a CRC. Each bit is a low pulse whose width gives its value. While sending, it samples the return line at the end of each bit slot.

When the last CRC bit ends, the frame line rises. The received data word and a CRC error flag are then offered on the receive stream. The transmit word is popped only in the cycle that the receive word is accepted. After that, a programmable idle gap must pass before another frame can begin.

Both streams use valid/ready handshakes. The transmit source must hold `tx_data` stable while `tx_valid` is high until `tx_ready` pulses. `tx_ready` is high only in the cycle where the receive handshake completes. The receive side may hold `rx_ready` low for any number of cycles. While it does, `rx_valid`, `rx_data` and `rx_crc_err` keep their values, and the gap and the next frame are delayed.

Top module: `pwfe_engine`

## Requirements
- R1: After reset, `frm_n` = 1, `txd` = 1, `rx_valid` = 0 and `tx_ready` = 0.
- R2: When the engine is idle and `tx_valid` = 1 at a clock edge, `frm_n` goes low from that edge. It stays low for exactly (1+N)·T clocks, where N = data length + CRC length and T = 3·`cfg_div`.
- R3: During the first T clocks of a frame (the lead-in), `txd` stays high.
- R4: Each bit slot lasts T clocks. `txd` is low for the first `cfg_div` clocks of the slot. In the middle `cfg_div` clocks it equals the bit value, so a 1 gives a 1/3 low pulse and a 0 gives a 2/3 low pulse. It is high for the last `cfg_div` clocks.
- R5: The bits are sent in this order: `tx_data[dlen-1]` down to `tx_data[0]`, then the CRC bits, most significant bit first. `cfg_dlen` takes values 1 to 16.
- R6: The CRC is an L-bit LFSR, with L = `cfg_clen` from 0 to 4. It starts at zero and runs over the data bits, most significant bit first. Each step computes fb = bit XOR crc[L-1], shifts crc left within L bits, and XORs in the low L bits of polynomial 4'h3 when fb = 1. L = 0 sends no CRC bits.
- R7: `rxd` is sampled on the last clock of each bit slot. `rx_data` holds the received data bits in their low `dlen` bits, MSB first, with all higher bits zero.
- R8: `rx_crc_err` = 1 exactly when the received data and CRC bits, run through the R6 LFSR, leave a nonzero remainder. It is always 0 when L = 0.
- R9: `rx_valid` rises on the clock after the frame ends. While `rx_ready` = 0, `rx_valid`, `rx_data` and `rx_crc_err` hold steady. `tx_ready` = 1 only in the cycle where `rx_valid` and `rx_ready` are both 1.
- R10: After the receive handshake, the engine waits `cfg_gap` clocks (sampled at the handshake), then one idle clock, before it can start the next frame. `frm_n` stays high throughout.
- R11: `cfg_dlen`, `cfg_clen` and `cfg_div` are captured when a frame starts. Changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word popped (frame complete and receive word accepted) |
| tx_data | input | 16 | Transmit word, right-aligned |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Receive word accepted |
| rx_data | output | 16 | Received data bits, right-aligned |
| rx_crc_err | output | 1 | Received CRC mismatch |
| cfg_dlen | input | 5 | Data bits per frame, 1 to 16 |
| cfg_clen | input | 3 | CRC bits per frame, 0 to 4 |
| cfg_div | input | 8 | Clocks per third of a bit, at least 1 |
| cfg_gap | input | 8 | Minimum idle clocks between frames |
| frm_n | output | 1 | Frame line, low during a frame |
| txd | output | 1 | Pulse-width transmit data line |
| rxd | input | 1 | Return data line |

## Verification
Five back-to-back frames are sent, covering the shortest frame (one data bit, one CRC bit), a full 16-bit word with no CRC, and frames with 3-bit and 4-bit CRCs. The divider ranges from 1 to 3, which separates the 1/3 and 2/3 pulse edges from an off-by-one in the third counter. Some replies echo a correct codeword and some have their last bit flipped. This tells a correct CRC check apart from one that ignores the CRC bits, or that flags errors when there is no CRC. A frame with receive back-pressure and differing gap values, including zero, shows whether the pop, the held receive word and the gap timing line up cycle for cycle. Scrambled configuration values are driven during each frame to show they are captured only at frame start.

// File: rtl/pwfe_pkg.sv
package pwfe_pkg;
  localparam int CRC_MAX = 4;
  localparam int CLEN_W  = $clog2(CRC_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITS,
    ST_DONE,
    ST_GAP
  } pw_state_t;

  // One LFSR step over a CRC of run-time length len (0..CRC_MAX).
  function automatic logic [CRC_MAX-1:0] crc_step(
    input logic [CRC_MAX-1:0] c,
    input logic               b,
    input logic [CLEN_W-1:0]  len,
    input logic [CRC_MAX-1:0] poly
  );
    logic [CRC_MAX-1:0] m;
    logic [CRC_MAX-1:0] top;
    logic [CRC_MAX-1:0] r;
    logic               fb;
    if (len == '0) return '0;
    m   = CRC_MAX'((1 << len) - 1);
    top = c >> (len - 1'b1);
    fb  = b ^ top[0];
    r   = (c << 1) & m;
    if (fb) r = r ^ (poly & m);
    return r;
  endfunction
endpackage

// File: rtl/pwfe_timer.sv
module pwfe_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic [1:0]       phase,
  output logic             bit_end
);
  logic [DIV_W-1:0] tcnt;
  logic             third_end;

  assign third_end = (tcnt == div - 1'b1);
  assign bit_end   = en && third_end && (phase == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      phase <= 2'd0;
    end else if (!en) begin
      tcnt  <= '0;
      phase <= 2'd0;
    end else if (third_end) begin
      tcnt  <= '0;
      phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  // R4: a bit slot has exactly three thirds
  a_r4_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
  // R4: the phase counter restarts from zero whenever the timer is halted
  a_r4_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == 2'd0));
endmodule

// File: rtl/pwfe_crc.sv
module pwfe_crc
  import pwfe_pkg::*;
#(
  parameter logic [CRC_MAX-1:0] POLY = 4'h3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic               din,
  input  logic [CLEN_W-1:0]  len,
  output logic [CRC_MAX-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc_step(crc, din, len, POLY);
  end
endmodule

// File: rtl/pwfe_engine.sv
module pwfe_engine
  import pwfe_pkg::*;
#(
  parameter int                 DATA_W   = 16,
  parameter int                 DIV_W    = 8,
  parameter int                 GAP_W    = 8,
  parameter logic [CRC_MAX-1:0] CRC_POLY = 4'h3,
  localparam int                LEN_W    = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_crc_err,
  input  logic [LEN_W-1:0]  cfg_dlen,
  input  logic [CLEN_W-1:0] cfg_clen,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [GAP_W-1:0]  cfg_gap,
  output logic              frm_n,
  output logic              txd,
  input  logic              rxd
);
  localparam int FRM_W = DATA_W + CRC_MAX;
  localparam int CNT_W = $clog2(FRM_W + 1);

  pw_state_t          state;
  logic [DIV_W-1:0]   div_q;
  logic [CLEN_W-1:0]  clen_q;
  logic [CNT_W-1:0]   total_q;
  logic [CNT_W-1:0]   bitcnt;
  logic [GAP_W-1:0]   gcnt;
  logic [FRM_W-1:0]   sh;
  logic [FRM_W-1:0]   rx_all;
  logic [CRC_MAX-1:0] rx_crc;
  logic [1:0]         phase;
  logic               bit_end;
  logic               busy;
  logic               start;

  // effective configuration (out-of-range values clamped)
  int                 dl;
  int                 cl;
  logic [CLEN_W-1:0]  clen_eff;
  logic [DIV_W-1:0]   div_eff;
  logic [CRC_MAX-1:0] crc_t;
  logic [FRM_W-1:0]   fbits;

  always_comb begin
    dl = int'(cfg_dlen);
    if (dl == 0 || dl > DATA_W) dl = DATA_W;
    cl = int'(cfg_clen);
    if (cl > CRC_MAX) cl = CRC_MAX;
    clen_eff = CLEN_W'(cl);
    div_eff  = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  end

  // transmit CRC over the data bits, then the left-aligned frame image
  always_comb begin
    logic [DATA_W-1:0]  dsh;
    logic [CRC_MAX-1:0] csh;
    crc_t = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dl) begin
        dsh   = tx_data >> (dl - 1 - i);
        crc_t = crc_step(crc_t, dsh[0], clen_eff, CRC_POLY);
      end
    end
    fbits = '0;
    for (int j = 0; j < FRM_W; j++) begin
      dsh = tx_data >> (dl - 1 - j);
      csh = crc_t >> (cl - 1 - (j - dl));
      if (j < dl)           fbits[FRM_W-1-j] = dsh[0];
      else if (j < dl + cl) fbits[FRM_W-1-j] = csh[0];
    end
  end

  assign busy  = (state == ST_LEAD) || (state == ST_BITS);
  assign start = (state == ST_IDLE) && tx_valid;

  pwfe_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (busy),
    .div     (div_q),
    .phase   (phase),
    .bit_end (bit_end)
  );

  pwfe_crc #(.POLY(CRC_POLY)) u_rxcrc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .en    ((state == ST_BITS) && bit_end),
    .din   (rxd),
    .len   (clen_q),
    .crc   (rx_crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      div_q   <= DIV_W'(1);
      clen_q  <= '0;
      total_q <= '0;
      bitcnt  <= '0;
      gcnt    <= '0;
      sh      <= '0;
      rx_all  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (tx_valid) begin
          state   <= ST_LEAD;
          div_q   <= div_eff;
          clen_q  <= clen_eff;
          total_q <= CNT_W'(dl + cl);
          bitcnt  <= '0;
          sh      <= fbits;
          rx_all  <= '0;
        end
        ST_LEAD: if (bit_end) state <= ST_BITS;
        ST_BITS: if (bit_end) begin
          sh     <= sh << 1;
          rx_all <= {rx_all[FRM_W-2:0], rxd};
          if (bitcnt == total_q - 1'b1) state <= ST_DONE;
          else bitcnt <= bitcnt + 1'b1;
        end
        ST_DONE: if (rx_ready) begin
          gcnt  <= cfg_gap;
          state <= (cfg_gap == '0) ? ST_IDLE : ST_GAP;
        end
        ST_GAP: begin
          if (gcnt == GAP_W'(1)) state <= ST_IDLE;
          gcnt <= gcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign frm_n      = !busy;
  assign txd        = (state != ST_BITS) ? 1'b1 :
                      (phase == 2'd0)    ? 1'b0 :
                      (phase == 2'd1)    ? sh[FRM_W-1] : 1'b1;
  assign rx_valid   = (state == ST_DONE);
  assign tx_ready   = rx_valid && rx_ready;
  assign rx_data    = DATA_W'(rx_all >> clen_q);
  assign rx_crc_err = (rx_crc != '0);

  // R3: the frame opens with the data line idle high
  a_r3_lead_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_n) |-> txd);
  // R2: the data line pulses only inside a frame
  a_r2_txd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |-> txd);
  // R9: pop only on a completed receive handshake
  a_r9_pop_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (rx_valid && rx_ready && frm_n));
  // R9: receive word held under back-pressure
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_crc_err)));
  // R10: no frame while the gap runs
  a_r10_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |=> frm_n || (state == ST_IDLE));
endmodule

// File: tb/sim_pwfe_engine.sv
module sim_pwfe_engine;
  localparam int NF   = 5;
  localparam int POLY = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [15:0] rx_data;
  logic        rx_crc_err;
  logic [4:0]  cfg_dlen = 5'd8;
  logic [2:0]  cfg_clen = 3'd0;
  logic [7:0]  cfg_div = 8'd1;
  logic [7:0]  cfg_gap = 8'd0;
  logic        frm_n;
  logic        txd;
  logic        rxd = 1'b1;

  always #5 clk = ~clk;

  pwfe_engine u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_crc_err(rx_crc_err), .cfg_dlen(cfg_dlen),
    .cfg_clen(cfg_clen), .cfg_div(cfg_div), .cfg_gap(cfg_gap),
    .frm_n(frm_n), .txd(txd), .rxd(rxd)
  );

  int f_dlen [NF] = '{8, 16, 1, 12, 10};
  int f_clen [NF] = '{4, 0, 1, 3, 4};
  int f_div  [NF] = '{1, 2, 1, 3, 1};
  int f_gap  [NF] = '{0, 3, 5, 2, 0};
  int f_data [NF] = '{'h00A5, 'h8001, 'h0001, 'h0B3C, 'h02D9};
  int f_resp [NF] = '{'h005A, 'h1234, 'h0000, 'h0A51, 'h0317};
  int f_bad  [NF] = '{0, 1, 1, 0, 1};
  int f_hold [NF] = '{0, 2, 0, 4, 1};

  int errors = 0;
  int checks = 0;
  bit go = 0;
  bit finished = 0;

  // behavioural model state
  int mst = 0;            // 0 idle, 1 frame, 2 done, 3 gap
  int fcyc, gcnt, idx, hcnt;
  int m_dl, m_cl, m_div, m_T, m_N;
  bit txb [24];
  bit rsp [24];
  bit rxb [24];
  int exp_rx, exp_err;

  function automatic int crc_rem(input bit m[24], input int n, input int L, input int pad);
    int g = (1 << L) | (POLY & ((1 << L) - 1));
    int r = 0;
    for (int i = 0; i < n + pad; i++) begin
      r = (r << 1) | ((i < n) ? int'(m[i]) : 0);
      if (((r >> L) & 1) != 0) r = r ^ g;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update at the edge, then drive inputs just after it
  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; idx = 0;
    end else begin
      case (mst)
        0: if (tx_valid) begin
          int c;
          bit db [24];
          mst = 1; fcyc = 0;
          m_dl = f_dlen[idx]; m_cl = f_clen[idx]; m_div = f_div[idx];
          m_T = 3 * m_div; m_N = m_dl + m_cl;
          for (int i = 0; i < 24; i++) begin db[i] = 0; rxb[i] = 0; end
          for (int i = 0; i < m_dl; i++) db[i] = bit'((f_data[idx] >> (m_dl - 1 - i)) & 1);
          c = crc_rem(db, m_dl, m_cl, m_cl);
          for (int i = 0; i < 24; i++) txb[i] = (i < m_dl) ? db[i] : 1'b0;
          for (int i = 0; i < m_cl; i++) txb[m_dl + i] = bit'((c >> (m_cl - 1 - i)) & 1);
          for (int i = 0; i < 24; i++) db[i] = 0;
          for (int i = 0; i < m_dl; i++) db[i] = bit'((f_resp[idx] >> (m_dl - 1 - i)) & 1);
          c = crc_rem(db, m_dl, m_cl, m_cl);
          for (int i = 0; i < 24; i++) rsp[i] = (i < m_dl) ? db[i] : 1'b0;
          for (int i = 0; i < m_cl; i++) rsp[m_dl + i] = bit'((c >> (m_cl - 1 - i)) & 1);
          if (f_bad[idx] != 0) rsp[m_N - 1] = ~rsp[m_N - 1];
        end
        1: begin
          if ((fcyc % m_T) == m_T - 1 && fcyc >= m_T) rxb[fcyc / m_T - 1] = rxd;
          if (fcyc == (m_N + 1) * m_T - 1) begin
            mst = 2; hcnt = 0;
            exp_rx = 0;
            for (int i = 0; i < m_dl; i++) exp_rx = (exp_rx << 1) | int'(rxb[i]);
            exp_err = (crc_rem(rxb, m_N, m_cl, 0) != 0) ? 1 : 0;
          end else fcyc++;
        end
        2: if (rx_ready) begin
          if (f_gap[idx] == 0) mst = 0; else begin mst = 3; gcnt = f_gap[idx]; end
          idx++;
        end
        default: if (gcnt == 1) mst = 0; else gcnt--;
      endcase
    end
    #1;
    tx_valid = go && (idx < NF);
    if (idx < NF) tx_data = 16'(f_data[idx]);
    if (mst == 1) begin
      cfg_dlen = 5'd3; cfg_clen = 3'd2; cfg_div = 8'd7;   // R11 scramble
      rxd = (fcyc >= m_T) ? rsp[fcyc / m_T - 1] : 1'b1;
    end else begin
      if (idx < NF) begin
        cfg_dlen = 5'(f_dlen[idx]); cfg_clen = 3'(f_clen[idx]);
        cfg_div = 8'(f_div[idx]); cfg_gap = 8'(f_gap[idx]);
      end
      rxd = 1'b1;
    end
    if (mst == 2 && hcnt < f_hold[idx]) begin rx_ready = 1'b0; hcnt++; end
    else rx_ready = 1'b1;
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (rst_n && go && !finished) begin
      int w, bp, et;
      et = 1;
      if (mst == 1) begin
        w = fcyc % m_T; bp = fcyc / m_T - 1;
        if (bp < 0) et = 1;
        else if (w < m_div) et = 0;
        else if (w < 2 * m_div) et = int'(txb[bp]);
        else et = 1;
        chk("R2 R11 frame line", int'(frm_n), 0);
        if (bp < 0) chk("R3 lead-in", int'(txd), et);
        else if (w >= m_div && w < 2 * m_div)
          chk((bp >= m_dl) ? "R6 crc bit" : "R5 data bit", int'(txd), et);
        else chk("R4 pulse edge", int'(txd), et);
      end else begin
        chk((mst == 3) ? "R10 gap frame line" : "R2 frame line", int'(frm_n), 1);
        chk("R2 data line idle", int'(txd), 1);
      end
      chk("R9 rx_valid", int'(rx_valid), (mst == 2) ? 1 : 0);
      chk("R9 tx_ready", int'(tx_ready), (mst == 2 && rx_ready) ? 1 : 0);
      if (mst == 2) begin
        chk("R7 rx_data", int'(rx_data), exp_rx);
        chk("R8 rx_crc_err", int'(rx_crc_err), exp_err);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 frm_n", int'(frm_n), 1);
    chk("R1 txd", int'(txd), 1);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 tx_ready", int'(tx_ready), 0);
    go = 1;
    while (!(idx == NF && mst == 0)) @(posedge clk);
    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule